// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Unit

This block sits beside a serial port core and collects the core's seven event pulses into latched flag bits. It holds an enable mask that software changes only through two write-one registers: one that sets enable bits and one that clears them. It combines the enabled flags into a single interrupt line for the whole port. Software finds the cause by reading the flag register, then writes ones to that register to clear the flags it has handled.

The same unit drives two DMA request lines. The receive request goes up when the core reports that received data is ready, and it drops when the data register is read. The transmit request goes up when the core reports that its transmit buffer has emptied, and it drops when the data register is written. The data register itself lives in the core. This block decodes accesses to its address and passes read and write strobes to the core.

All state is registered on one clock and is cleared by a synchronous active-high reset. The bus is single-cycle: a write takes effect at the clock edge, and read data is a combinational function of the address and the registered state.

Top module: `serial_irq_dma_unit`

## Requirements
- R1: After reset every flag and every enable bit is zero, the interrupt output is low, the receive request is low and the transmit request is high.
- R2: A one on bit i of the event input sets flag i at the next clock edge. The bit order is: 0 error, 1 received break, 2 clear-to-send change, 3 receive start, 4 receive complete, 5 transmit complete, 6 data register empty.
- R3: A bus write to address 0 clears each flag whose write-data bit is one. Flags whose write-data bit is zero keep their value.
- R4: When a flag-clear write and an event for the same bit fall in the same cycle, that flag is set after the edge.
- R5: A bus write to address 1 sets each enable bit whose write-data bit is one. Zero bits in the write data leave the enable bits unchanged.
- R6: A bus write to address 2 clears each enable bit whose write-data bit is one. Zero bits in the write data leave the enable bits unchanged.
- R7: A read of address 0 returns the raw flags in bits 6..0, regardless of the enables. A read of address 1 or address 2 returns the enable mask. Unused bits read as zero.
- R8: The interrupt output is high exactly when some flag and its matching enable bit are both set. It stays high until that flag is cleared, that enable is cleared, or the block is reset.
- R9: A receive-data pulse sets the receive request at the next edge. A bus read of address 3 clears it. When both happen in the same cycle, the request is set.
- R10: A transmit-empty pulse sets the transmit request at the next edge. A bus write to address 3 clears it. When both happen in the same cycle, the request is set.
- R11: A bus read of address 3 raises the data-read strobe in the same cycle, and a bus write of address 3 raises the data-write strobe in the same cycle. A read of address 3 returns zero on this bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Event pulses from the core, one bit per source |
| rx_data_evt_i | input | 1 | Pulse: received data is ready |
| tx_empty_evt_i | input | 1 | Pulse: transmit buffer became empty |
| bus_sel_i | input | 1 | Bus access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address (0 flags, 1 enable set, 2 enable clear, 3 data) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| data_rd_o | output | 1 | Strobe to the core: the data register is being read |
| data_wr_o | output | 1 | Strobe to the core: the data register is being written |
| irq_o | output | 1 | Shared interrupt request |
| rx_req_o | output | 1 | Receive DMA request |
| tx_req_o | output | 1 | Transmit DMA request |

## Verification
Flags, enables and both DMA requests are single registers, so their effects show one edge after the stimulus. The interrupt output is combinational from those registers, so it also changes one edge after a flag or enable change. Read data and the two data strobes are combinational and are valid in the cycle of the access. The bench drives inputs on the falling edge and samples read data before the next rising edge. It samples the interrupt and request outputs just after that rising edge, so each check sees the state exactly one register stage after the stimulus.

// File: rtl/spirq_pkg.sv
package spirq_pkg;

    localparam int NSRC   = 7;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAGS  = 2'd0,
        REG_EN_SET = 2'd1,
        REG_EN_CLR = 2'd2,
        REG_DATA   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             sel;
        logic             wr;
        reg_addr_e        addr;
        logic [BUS_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic            flag_clr;
        logic            en_set;
        logic            en_clr;
        logic            data_rd;
        logic            data_wr;
        logic [NSRC-1:0] mask;
    } reg_cmd_t;

    function automatic reg_cmd_t decode_access(bus_req_t b);
        reg_cmd_t c;
        logic     w;
        logic     r;
        w          = b.sel &  b.wr;
        r          = b.sel & ~b.wr;
        c.flag_clr = w && (b.addr == REG_FLAGS);
        c.en_set   = w && (b.addr == REG_EN_SET);
        c.en_clr   = w && (b.addr == REG_EN_CLR);
        c.data_wr  = w && (b.addr == REG_DATA);
        c.data_rd  = r && (b.addr == REG_DATA);
        c.mask     = b.wdata[NSRC-1:0];
        return c;
    endfunction

endpackage

// File: rtl/spirq_flag_bank.sv
module spirq_flag_bank
    import spirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] event_in,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (event_in[i])
                bit_q <= 1'b1;
            else if (clr_wr && clr_mask[i])
                bit_q <= 1'b0;
        end
        assign flags[i] = bit_q;
    end
endmodule

// File: rtl/spirq_enable_mask.sv
module spirq_enable_mask
    import spirq_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] en
);
    logic [N-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (set_wr)
            en_q <= en_q | mask;
        else if (clr_wr)
            en_q <= en_q & ~mask;
    end

    assign en = en_q;
endmodule

// File: rtl/spirq_dma_req.sv
module spirq_dma_req #(
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_pulse,
    input  logic clr_access,
    output logic req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst)
            req_q <= RESET_VAL;
        else if (set_pulse)
            req_q <= 1'b1;
        else if (clr_access)
            req_q <= 1'b0;
    end

    assign req = req_q;
endmodule

// File: rtl/serial_irq_dma_unit.sv
module serial_irq_dma_unit
    import spirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   evt_i,
    input  logic              rx_data_evt_i,
    input  logic              tx_empty_evt_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              data_rd_o,
    output logic              data_wr_o,
    output logic              irq_o,
    output logic              rx_req_o,
    output logic              tx_req_o
);
    bus_req_t        req;
    reg_cmd_t        cmd;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;

    always_comb begin
        req.sel   = bus_sel_i;
        req.wr    = bus_wr_i;
        req.addr  = reg_addr_e'(bus_addr_i);
        req.wdata = bus_wdata_i;
        cmd       = decode_access(req);
    end

    spirq_flag_bank #(.N(NSRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .event_in (evt_i),
        .clr_wr   (cmd.flag_clr),
        .clr_mask (cmd.mask),
        .flags    (flag_q)
    );

    spirq_enable_mask #(.N(NSRC)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .set_wr (cmd.en_set),
        .clr_wr (cmd.en_clr),
        .mask   (cmd.mask),
        .en     (en_q)
    );

    spirq_dma_req #(.RESET_VAL(1'b0)) u_rx_req (
        .clk        (clk),
        .rst        (rst),
        .set_pulse  (rx_data_evt_i),
        .clr_access (cmd.data_rd),
        .req        (rx_req_o)
    );

    spirq_dma_req #(.RESET_VAL(1'b1)) u_tx_req (
        .clk        (clk),
        .rst        (rst),
        .set_pulse  (tx_empty_evt_i),
        .clr_access (cmd.data_wr),
        .req        (tx_req_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i) begin
            unique case (req.addr)
                REG_FLAGS:              bus_rdata_o[NSRC-1:0] = flag_q;
                REG_EN_SET, REG_EN_CLR: bus_rdata_o[NSRC-1:0] = en_q;
                default:                bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o     = |(flag_q & en_q);
    assign data_rd_o = cmd.data_rd;
    assign data_wr_o = cmd.data_wr;
endmodule

// File: rtl/spirq_checker.sv
module spirq_checker
    import spirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   evt_i,
    input logic              rx_data_evt_i,
    input logic              tx_empty_evt_i,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [BUS_W-1:0]  bus_wdata_i,
    input logic              irq_o,
    input logic              rx_req_o,
    input logic              tx_req_o,
    input logic [NSRC-1:0]   flags,
    input logic [NSRC-1:0]   en
);
    logic            wr_fl;
    logic            wr_es;
    logic            wr_ec;
    logic            rd_dat;
    logic            wr_dat;
    logic [NSRC-1:0] wmask;

    assign wr_fl  = bus_sel_i &&  bus_wr_i && (bus_addr_i == 2'd0);
    assign wr_es  = bus_sel_i &&  bus_wr_i && (bus_addr_i == 2'd1);
    assign wr_ec  = bus_sel_i &&  bus_wr_i && (bus_addr_i == 2'd2);
    assign wr_dat = bus_sel_i &&  bus_wr_i && (bus_addr_i == 2'd3);
    assign rd_dat = bus_sel_i && !bus_wr_i && (bus_addr_i == 2'd3);
    assign wmask  = bus_wdata_i[NSRC-1:0];

    a_r2_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

    a_r3_clear_takes_effect: assert property (@(posedge clk) disable iff (rst)
        wr_fl |=> ((flags & $past(wmask & ~evt_i)) == '0));

    a_r5_enable_set: assert property (@(posedge clk) disable iff (rst)
        wr_es |=> ((en & $past(wmask)) == $past(wmask)));

    a_r6_enable_clear: assert property (@(posedge clk) disable iff (rst)
        wr_ec |=> ((en & $past(wmask)) == '0));

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !wr_fl && !wr_ec) |=> irq_o);

    a_r9_rx_set: assert property (@(posedge clk) disable iff (rst)
        rx_data_evt_i |=> rx_req_o);

    a_r9_rx_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_dat && !rx_data_evt_i) |=> !rx_req_o);

    a_r10_tx_set: assert property (@(posedge clk) disable iff (rst)
        tx_empty_evt_i |=> tx_req_o);

    a_r10_tx_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_dat && !tx_empty_evt_i) |=> !tx_req_o);
endmodule

bind serial_irq_dma_unit spirq_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .evt_i          (evt_i),
    .rx_data_evt_i  (rx_data_evt_i),
    .tx_empty_evt_i (tx_empty_evt_i),
    .bus_sel_i      (bus_sel_i),
    .bus_wr_i       (bus_wr_i),
    .bus_addr_i     (bus_addr_i),
    .bus_wdata_i    (bus_wdata_i),
    .irq_o          (irq_o),
    .rx_req_o       (rx_req_o),
    .tx_req_o       (tx_req_o),
    .flags          (flag_q),
    .en             (en_q)
);

// File: tb/serial_irq_dma_unit_test.sv
module serial_irq_dma_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] evt_i = '0;
    logic       rx_data_evt_i = 1'b0;
    logic       tx_empty_evt_i = 1'b0;
    logic       bus_sel_i = 1'b0;
    logic       bus_wr_i = 1'b0;
    logic [1:0] bus_addr_i = '0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       data_rd_o;
    logic       data_wr_o;
    logic       irq_o;
    logic       rx_req_o;
    logic       tx_req_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serial_irq_dma_unit uut (
        .clk            (clk),
        .rst            (rst),
        .evt_i          (evt_i),
        .rx_data_evt_i  (rx_data_evt_i),
        .tx_empty_evt_i (tx_empty_evt_i),
        .bus_sel_i      (bus_sel_i),
        .bus_wr_i       (bus_wr_i),
        .bus_addr_i     (bus_addr_i),
        .bus_wdata_i    (bus_wdata_i),
        .bus_rdata_o    (bus_rdata_o),
        .data_rd_o      (data_rd_o),
        .data_wr_o      (data_wr_o),
        .irq_o          (irq_o),
        .rx_req_o       (rx_req_o),
        .tx_req_o       (tx_req_o)
    );

    typedef struct packed {
        logic       sel;
        logic       wr;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [6:0] evt;
        logic       rxe;
        logic       txe;
        logic [7:0] exp_rd;
        logic       exp_irq;
        logic       exp_rx;
        logic       exp_tx;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,2'd0,8'h00,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd1},  // R1 flags zero
        '{1'b1,1'b0,2'd1,8'h00,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd1},  // R1 enables zero
        '{1'b0,1'b0,2'd0,8'h00,7'h05,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd2},  // R2 error + cts change
        '{1'b1,1'b0,2'd0,8'h00,7'h00,1'b0,1'b0,8'h05,1'b0,1'b0,1'b1,4'd7},  // R7 raw flags
        '{1'b1,1'b1,2'd1,8'h04,7'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,4'd5},  // R5 set enable 2
        '{1'b1,1'b0,2'd2,8'h00,7'h00,1'b0,1'b0,8'h04,1'b1,1'b0,1'b1,4'd7},  // R7 mask via clr addr
        '{1'b1,1'b1,2'd1,8'h00,7'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,4'd5},  // R5 zero write
        '{1'b1,1'b0,2'd1,8'h00,7'h00,1'b0,1'b0,8'h04,1'b1,1'b0,1'b1,4'd5},  // R5 mask kept
        '{1'b1,1'b1,2'd0,8'h01,7'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,4'd3},  // R3 clear error only
        '{1'b1,1'b0,2'd0,8'h00,7'h00,1'b0,1'b0,8'h04,1'b1,1'b0,1'b1,4'd3},  // R3 other flag kept
        '{1'b1,1'b1,2'd0,8'h04,7'h04,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,4'd4},  // R4 event beats clear
        '{1'b1,1'b0,2'd0,8'h00,7'h00,1'b0,1'b0,8'h04,1'b1,1'b0,1'b1,4'd4},  // R4
        '{1'b1,1'b1,2'd2,8'h00,7'h00,1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,4'd6},  // R6 zero write
        '{1'b1,1'b1,2'd2,8'h04,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd6},  // R6 clear enable
        '{1'b1,1'b0,2'd0,8'h00,7'h00,1'b0,1'b0,8'h04,1'b0,1'b0,1'b1,4'd7},  // R7 flag while disabled
        '{1'b1,1'b1,2'd0,8'h04,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd3},  // R3
        '{1'b1,1'b0,2'd0,8'h00,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd3},  // R3
        '{1'b0,1'b0,2'd0,8'h00,7'h00,1'b1,1'b0,8'h00,1'b0,1'b1,1'b1,4'd9},  // R9 rx set
        '{1'b1,1'b0,2'd3,8'h00,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd9},  // R9 rx cleared by read
        '{1'b1,1'b0,2'd3,8'h00,7'h00,1'b1,1'b0,8'h00,1'b0,1'b1,1'b1,4'd9},  // R9 set wins
        '{1'b1,1'b0,2'd3,8'h00,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b1,4'd9},  // R9
        '{1'b1,1'b1,2'd3,8'h55,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'd10}, // R10 tx cleared by write
        '{1'b0,1'b0,2'd0,8'h00,7'h00,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,4'd10}, // R10 tx set
        '{1'b1,1'b1,2'd3,8'h00,7'h00,1'b0,1'b1,8'h00,1'b0,1'b0,1'b1,4'd10}, // R10 set wins
        '{1'b1,1'b1,2'd3,8'h00,7'h00,1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,4'd10}, // R10
        '{1'b1,1'b1,2'd1,8'h7F,7'h7F,1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,4'd8},  // R8 all sources
        '{1'b1,1'b0,2'd0,8'h00,7'h00,1'b0,1'b0,8'h7F,1'b1,1'b0,1'b0,4'd7},  // R7
        '{1'b1,1'b0,2'd2,8'h00,7'h00,1'b0,1'b0,8'h7F,1'b1,1'b0,1'b0,4'd7}   // R7
    };

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic w, input logic [1:0] a, input logic [7:0] d,
                         input logic [6:0] e, input logic rx, input logic tx);
        bus_sel_i = s; bus_wr_i = w; bus_addr_i = a; bus_wdata_i = d;
        evt_i = e; rx_data_evt_i = rx; tx_empty_evt_i = tx;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 2'd0, 8'h00, 7'h00, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "irq", {7'd0, irq_o}, 8'h00);
        check("R1", "rx_req", {7'd0, rx_req_o}, 8'h00);
        check("R1", "tx_req", {7'd0, tx_req_o}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].sel, VECS[i].wr, VECS[i].addr, VECS[i].wdata,
                  VECS[i].evt, VECS[i].rxe, VECS[i].txe);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            #1;
            if (VECS[i].sel && !VECS[i].wr)
                check(tag, "rdata", bus_rdata_o, VECS[i].exp_rd);
            @(posedge clk);
            #1;
            check(tag, "irq", {7'd0, irq_o}, {7'd0, VECS[i].exp_irq});
            check(tag, "rx_req", {7'd0, rx_req_o}, {7'd0, VECS[i].exp_rx});
            check(tag, "tx_req", {7'd0, tx_req_o}, {7'd0, VECS[i].exp_tx});
        end

        // R11: data strobes appear combinationally in the access cycle
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd3, 8'h00, 7'h00, 1'b0, 1'b0);
        #1;
        check("R11", "data_rd on read", {7'd0, data_rd_o}, 8'h01);
        check("R11", "data_wr on read", {7'd0, data_wr_o}, 8'h00);
        @(negedge clk);
        drive(1'b1, 1'b1, 2'd3, 8'hA5, 7'h00, 1'b0, 1'b0);
        #1;
        check("R11", "data_rd on write", {7'd0, data_rd_o}, 8'h00);
        check("R11", "data_wr on write", {7'd0, data_wr_o}, 8'h01);
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd0, 8'h00, 7'h00, 1'b0, 1'b0);
        #1;
        check("R11", "no strobe on flag read", {6'd0, data_rd_o, data_wr_o}, 8'h00);

        // R8: clearing every flag drops irq while enables remain
        @(negedge clk);
        drive(1'b1, 1'b1, 2'd0, 8'h7F, 7'h00, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R8", "irq after flag clear", {7'd0, irq_o}, 8'h00);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 8'h00, 7'h40, 1'b1, 1'b0);
        @(posedge clk); #1;
        check("R8", "irq from data-empty source", {7'd0, irq_o}, 8'h01);
        check("R9", "rx set before reset", {7'd0, rx_req_o}, 8'h01);

        // R1: reset in mid-run restores the initial state
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 1'b0, 2'd0, 8'h00, 7'h00, 1'b0, 1'b0);
        #1;
        check("R1", "flags after reset", bus_rdata_o, 8'h00);
        check("R1", "irq after reset", {7'd0, irq_o}, 8'h00);
        check("R1", "rx_req after reset", {7'd0, rx_req_o}, 8'h00);
        check("R1", "tx_req after reset", {7'd0, tx_req_o}, 8'h01);
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd1, 8'h00, 7'h00, 1'b0, 1'b0);
        #1;
        check("R1", "enables after reset", bus_rdata_o, 8'h00);
        @(negedge clk);
        idle();

        done = 1'b1;
        summary();
    end

endmodule